// File: doc/BRIEF.md
# Dual-Compare 16-bit Timer Counter

This block is a 16-bit up-counter with two compare channels, called N and M. A 2-bit run field starts and stops it. A 2-bit mode input chooses how the count is cleared and how the single timer output pin behaves. Four modes are provided:
- periodic clear on an N match;
- free-running with wrap at the top of the range;
- restart on a rising edge of an asynchronous event input;
- pulse-width generation, where N sets the period and M sets the high time.

Each compare channel gives one single-cycle match pulse, and the counter gives a one-cycle overflow pulse.

Compare values enter as plain inputs. Each value is copied into a shadow register while the timer is stopped and at every clear event. A value changed in the middle of a period therefore takes effect only in the next period.

A compare value of zero is handled specially. It never matches in the first step after start. After a clear event, it matches on the step of the count from 0 to 1.

Top module: `dual_cmp_timer`

## Requirements
- R1: While `run_en` is 00, `count` is held at 0 and `tout`, `match_n`, `match_m` and `ovf` are 0. Any nonzero `run_en` value enables counting.
- R2: While enabled and with no clear event, `count` rises by exactly one per clock.
- R3: Mode 00 (periodic) clears the count on the clock after it equals a nonzero shadow N, so the period is N+1 clocks.
- R4: Mode 01 (free-running) wraps from FFFFh to 0. `ovf` is high for the one cycle in which `count` is 0 after the wrap.
- R5: Mode 10 (edge restart) passes `ext_evt` through two synchroniser flops. A rising edge clears the count on the third clock edge after the input rises. In every other mode the edge has no effect on the count.
- R6: Mode 11 (pulse width) clears the count on an N match, like mode 00. `tout` is set by the N match and reset by the M match. Both changes appear one clock after the equality, so `tout` is high while `count` is in 0..M.
- R7: A compare value of 0 gives no match pulse in the first step after start. After any clear event while running, it pulses when `count` steps from 0 to 1.
- R8: `match_n` and `match_m` are single-cycle pulses, asserted in the cycle after `count` equals the shadow value.
- R9: A change on `cmp_n` or `cmp_m` is taken into the shadow only while stopped or at a clear event.
- R10: In modes 00, 01 and 10, `tout` toggles on every N match pulse. It starts at 0 when counting starts.
- R11: When a clear from an N match or an external edge coincides with the count reaching FFFFh, `ovf` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 2 | Run field; 00 stops and zeroes the counter |
| mode | input | 2 | 00 periodic, 01 free-run, 10 edge restart, 11 pulse width |
| cmp_n | input | 16 | Compare value N (period / clear) |
| cmp_m | input | 16 | Compare value M (duty) |
| ext_evt | input | 1 | Asynchronous restart event |
| count | output | 16 | Current counter value |
| match_n | output | 1 | N match pulse |
| match_m | output | 1 | M match pulse |
| ovf | output | 1 | Overflow pulse |
| tout | output | 1 | Timer output pin |

## Verification
The checks take for granted that the compare values obey each mode's ranges:
- N is nonzero in the periodic and pulse-width modes;
- M is below N in pulse-width mode;
- external rising edges are at least three clocks apart.

Without these, the single-cycle pulse and fall-on-M properties are not promised. The directed stimulus changes mode only while the run field is 00, and it always picks values inside these ranges. The one exception is a mid-period write that stays legal.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_PERIODIC = 2'b00,
    MODE_FREE     = 2'b01,
    MODE_EXTCLR   = 2'b10,
    MODE_PWM      = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // pipe[0..STAGES-1] is the synchroniser, pipe[STAGES] holds the previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] new_val,
  input  logic [W-1:0] cnt,
  input  logic         armed,
  input  logic         step,
  output logic [W-1:0] val,
  output logic         hit
);
  // Nonzero value: equality. Zero value: only on the 0->1 step after a clear.
  function automatic logic hit_f(input logic [W-1:0] c, input logic [W-1:0] v,
                                 input logic arm, input logic st);
    logic zero_v;
    zero_v = (v == '0);
    return st && ((!zero_v && c == v) || (zero_v && arm && c == '0));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val <= '0;
    else if (load) val <= new_val;
  end

  assign hit = hit_f(cnt, val, armed, step);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int W      = 16,
  parameter int SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   run_en,
  input  logic [1:0]   mode,
  input  logic [W-1:0] cmp_n,
  input  logic [W-1:0] cmp_m,
  input  logic         ext_evt,
  output logic [W-1:0] count,
  output logic         match_n,
  output logic         match_m,
  output logic         ovf,
  output logic         tout
);
  import tmr_pkg::*;

  localparam int         NCMP = 2;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  tmr_mode_e    md;
  logic         running;
  logic         ext_rise;
  logic         zarm;
  logic         clr_evt;
  logic         n_clr;
  logic         ext_clr;
  logic         at_top;
  logic         ovf_evt;
  logic [W-1:0] cmp_in  [NCMP];
  logic [W-1:0] shadow  [NCMP];
  logic [NCMP-1:0] hits;

  assign md      = tmr_mode_e'(mode);
  assign running = (run_en != 2'b00);

  tmr_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (ext_evt), .rise (ext_rise)
  );

  assign cmp_in[0] = cmp_n;
  assign cmp_in[1] = cmp_m;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    tmr_cmp_unit #(.W(W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (!running || clr_evt),
      .new_val (cmp_in[i]),
      .cnt     (count),
      .armed   (zarm),
      .step    (running),
      .val     (shadow[i]),
      .hit     (hits[i])
    );
  end

  // Clear sources
  assign n_clr   = hits[0] && (shadow[0] != '0) &&
                   (md == MODE_PERIODIC || md == MODE_PWM);
  assign ext_clr = (md == MODE_EXTCLR) && ext_rise;
  assign at_top  = (count == TOP);
  assign clr_evt = running && (n_clr || ext_clr || at_top);
  assign ovf_evt = running && at_top && !n_clr && !ext_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      zarm  <= 1'b0;
    end else if (!running) begin
      count <= '0;
      zarm  <= 1'b0;
    end else if (clr_evt) begin
      count <= '0;
      zarm  <= 1'b1;
    end else begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_n <= 1'b0;
      match_m <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      match_n <= hits[0];
      match_m <= hits[1];
      ovf     <= ovf_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tout <= 1'b0;
    else if (!running)       tout <= 1'b0;
    else if (md == MODE_PWM) begin
      if (hits[1])           tout <= 1'b0;
      else if (hits[0])      tout <= 1'b1;
    end else if (hits[0])    tout <= ~tout;
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  run_en,
  input logic [1:0]  mode,
  input logic [15:0] count,
  input logic        match_n,
  input logic        match_m,
  input logic        ovf,
  input logic        tout
);
  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en == 2'b00) |=> (count == 16'h0 && !tout && !match_n && !match_m && !ovf));

  // R4
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == 16'h0 && $past(count) == 16'hFFFF));

  // R8
  match_n_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_n |=> !match_n);

  // R8
  match_m_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_m |=> !match_m);

  // R7
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en != 2'b00 && $past(run_en) == 2'b00) |=> (!match_n && !match_m));

  // R6
  pwm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tout) && $past(mode) == 2'b11 && $past(run_en) != 2'b00) |-> match_m);
endmodule

bind dual_cmp_timer tmr_chk u_tmr_chk (
  .clk (clk), .rst_n (rst_n), .run_en (run_en), .mode (mode),
  .count (count), .match_n (match_n), .match_m (match_m),
  .ovf (ovf), .tout (tout)
);

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  run_en = 2'b00;
  logic [1:0]  mode = 2'b00;
  logic [15:0] cmp_n = 16'h0;
  logic [15:0] cmp_m = 16'h0;
  logic        ext_evt = 1'b0;
  logic [15:0] count;
  logic        match_n, match_m, ovf, tout;

  int checks = 0;
  int errors = 0;
  int k = 0;

  always #4 clk = ~clk;

  dual_cmp_timer dut (
    .clk (clk), .rst_n (rst_n), .run_en (run_en), .mode (mode),
    .cmp_n (cmp_n), .cmp_m (cmp_m), .ext_evt (ext_evt),
    .count (count), .match_n (match_n), .match_m (match_m),
    .ovf (ovf), .tout (tout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s k=%0d actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    k++;
  endtask

  task automatic begin_run(input logic [1:0] md, input logic [15:0] nv,
                           input logic [15:0] mv, input logic [1:0] en);
    @(negedge clk);
    run_en = 2'b00; mode = md; cmp_n = nv; cmp_m = mv; ext_evt = 1'b0;
    repeat (4) @(negedge clk);
    run_en = en;
    k = 0;
  endtask

  task automatic t_reset();
    chk(count == 0 && !tout && !match_n && !match_m && !ovf, "R1 reset", count, 0);
  endtask

  // R3 R8 R10 R2 R1: periodic mode N=5, enabled through run value 10
  task automatic t_periodic();
    bit exp_t = 1'b0;
    begin_run(2'b00, 16'd5, 16'd9, 2'b10);
    for (int i = 1; i <= 14; i++) begin
      tick();
      chk(count == k % 6, "R3/R2 count", count, k % 6);
      chk(match_n == (k == 6 || k == 12), "R8 match_n", match_n, (k == 6 || k == 12));
      if (k == 6 || k == 12) exp_t = ~exp_t;
      chk(tout == exp_t, "R10 tout toggle", tout, exp_t);
    end
    run_en = 2'b00;
    tick();
    chk(count == 0 && !tout, "R1 stop", count, 0);
    tick();
    chk(count == 0, "R1 held", count, 0);
  endtask

  // R7: zero M in periodic mode N=4
  task automatic t_zero_cmp();
    begin_run(2'b00, 16'd4, 16'd0, 2'b01);
    for (int i = 1; i <= 12; i++) begin
      tick();
      chk(match_m == (k == 6 || k == 11), "R7 zero match", match_m, (k == 6 || k == 11));
    end
  endtask

  // R6: pulse width N=6 M=2
  task automatic t_pwm();
    bit e;
    begin_run(2'b11, 16'd6, 16'd2, 2'b01);
    for (int i = 1; i <= 20; i++) begin
      tick();
      e = (k >= 7) && ((k % 7) <= 2);
      chk(tout == e, "R6 tout", tout, e);
      chk(count == k % 7, "R6 count", count, k % 7);
    end
  endtask

  // R5: edge restart and R7 zero N after edge clear
  task automatic t_ext();
    begin_run(2'b10, 16'd0, 16'd0, 2'b01);
    repeat (10) tick();
    chk(count == 10, "R2 count", count, 10);
    ext_evt = 1'b1;
    tick(); tick();
    chk(count == 12, "R5 sync delay", count, 12);
    tick();
    chk(count == 0, "R5 edge clear", count, 0);
    tick();
    chk(count == 1, "R5 resume", count, 1);
    chk(match_n == 1'b1, "R7 zero after edge", match_n, 1);
    begin_run(2'b01, 16'd100, 16'd200, 2'b01);
    repeat (5) tick();
    ext_evt = 1'b1;
    repeat (3) tick();
    chk(count == 8, "R5 edge ignored", count, 8);
  endtask

  // R9: mid-period change of N
  task automatic t_shadow();
    begin_run(2'b00, 16'd5, 16'd0, 2'b01);
    tick(); tick();
    cmp_n = 16'd3;
    repeat (3) tick();
    chk(count == 5, "R9 old N kept", count, 5);
    tick();
    chk(count == 0, "R9 old clear", count, 0);
    repeat (3) tick();
    chk(count == 3, "R9 new N", count, 3);
    tick();
    chk(count == 0, "R9 new clear", count, 0);
  endtask

  // R4 and R7 at wrap in free-running mode
  task automatic t_free();
    begin_run(2'b01, 16'd0, 16'd0, 2'b01);
    tick();
    chk(!match_n, "R7 no start match", match_n, 0);
    repeat (65534) tick();
    chk(count == 16'hFFFF && !ovf, "R4 top", count, 16'hFFFF);
    tick();
    chk(count == 0 && ovf, "R4 ovf", ovf, 1);
    tick();
    chk(!ovf && count == 1, "R4 ovf single", ovf, 0);
    chk(match_n, "R7 match after wrap", match_n, 1);
  endtask

  // R11: N=FFFF periodic
  task automatic t_top_match();
    begin_run(2'b00, 16'hFFFF, 16'd0, 2'b01);
    repeat (65536) tick();
    chk(count == 0, "R11 clear", count, 0);
    chk(!ovf, "R11 ovf suppressed", ovf, 0);
    chk(match_n, "R11 match", match_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_zero_cmp();
    t_pwm();
    t_ext();
    t_shadow();
    t_free();
    t_top_match();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", k, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule